// File: doc/BRIEF.md
# Scoreboard Instruction Scheduler

This block schedules decoded instructions onto five multi-cycle execution units: an integer/load unit, an adder (add and subtract), two multipliers and a divider. One instruction is accepted per cycle on a valid/ready handshake. It then moves through four steps: issue, operand read, execute and result write. Issue is in order. Operand read, execution and result write happen out of order, each as soon as its hazard condition clears.

The execution units are modelled as countdown timers and carry no data. The block tells the surrounding pipeline when a unit reads its operands (a start pulse) and when a unit owns the single register-file write port (a one-hot write grant plus the destination index). It also exposes its per-unit and per-register status for checking. Results are not forwarded: a consumer reads a register only after the producer's write grant.

Top module: `scoreboard_sched`

## Requirements
- R1: After reset every unit is idle, every register owner field holds the empty code 7, no start or write grant is active, and in_ready is high for any class.
- R2: Class codes are 0 integer/load, 1 add/subtract, 2 multiply, 3 divide. An instruction is held (in_ready low) while its unit is busy. A multiply takes unit 2 when it is free, otherwise unit 3, and is held while both are busy.
- R3: An instruction is held while its destination register already has an owner. While it is held, no other instruction is accepted.
- R4: On acceptance, the destination register's owner field (3 bits per register, register r at bits 3r+2..3r) takes the unit code: 0 integer, 1 adder, 2 first multiplier, 3 second multiplier, 4 divider.
- R5: A unit reads its operands (a one-cycle start pulse) in the first cycle in which neither source has a pending writer. This is at the earliest the cycle after acceptance. Otherwise it is the cycle after the producing unit's write grant.
- R6: Execute latencies are 1 (integer), 2 (adder), 10 (each multiplier) and 40 (divider) cycles. With a start in cycle s and no conflict, the write grant comes in cycle s+L+1.
- R7: A write grant sets the ready flag of every source waiting on that unit. An operand read clears both ready flags of the reading unit.
- R8: A finished unit does not write while any other unit that has not yet read its operands holds a ready source naming that destination.
- R9: At most one write grant is active per cycle. Among units ready to write, the lowest unit code wins.
- R10: A write grant clears the unit's busy flag and the register's owner field at the same edge. An instruction accepted in the write cycle that names the written register as a source counts that source as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_cls | input | 2 | Class code (R2) |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| start_vec | output | 5 | Per-unit operand-read pulse |
| wb_vec | output | 5 | One-hot write grant |
| wb_reg | output | 4 | Register written under the grant |
| fu_busy | output | 5 | Per-unit busy flags |
| fu_rdy_j | output | 5 | Per-unit first-source ready flags |
| fu_rdy_k | output | 5 | Per-unit second-source ready flags |
| reg_owner | output | 48 | Owner unit code per register, 7 when empty |

## Verification
The case that needs the most care is a write grant in the same cycle that a new instruction is accepted naming that register as a source. The bench lines this up by accepting the consumer in the exact cycle the integer unit's grant is due. It then requires the consumer's start pulse in the next cycle instead of a permanent wait. A second collision, a write grant against a pending operand read of the same register, is provoked with a divider feeding an adder whose other source is the integer unit's destination. The bench expects the integer write two cycles after the divider's.

// File: rtl/scoreboard_sched.sv
module scoreboard_sched #(
  parameter int NREG    = 16,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_cls,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_src1,
  input  logic [$clog2(NREG)-1:0] in_src2,
  output logic [4:0]              start_vec,
  output logic [4:0]              wb_vec,
  output logic [$clog2(NREG)-1:0] wb_reg,
  output logic [4:0]              fu_busy,
  output logic [4:0]              fu_rdy_j,
  output logic [4:0]              fu_rdy_k,
  output logic [NREG*3-1:0]       reg_owner
);
  localparam int RW   = $clog2(NREG);
  localparam int NU   = 5;
  localparam int UW   = 3;
  localparam int LM1  = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int LM2  = (LAT_ADD > LAT_INT) ? LAT_ADD : LAT_INT;
  localparam int LMAX = (LM1 > LM2) ? LM1 : LM2;
  localparam int TW   = $clog2(LMAX + 1);
  localparam logic [UW-1:0] NONE = '1;

  typedef enum logic [1:0] {P_IDLE, P_READ, P_EXEC, P_WRITE} phase_t;

  phase_t         ph  [NU];
  logic [RW-1:0]  fi  [NU];
  logic [RW-1:0]  fj  [NU];
  logic [RW-1:0]  fk  [NU];
  logic [UW-1:0]  qj  [NU];
  logic [UW-1:0]  qk  [NU];
  logic           rj  [NU];
  logic           rk  [NU];
  logic [TW-1:0]  tmr [NU];
  logic [UW-1:0]  rrs [NREG];

  logic [UW-1:0]  tgt;
  logic           issue;
  logic [NU-1:0]  war;
  logic [NU-1:0]  wreq;
  logic           wb_any;
  logic [UW-1:0]  wb_u;
  logic [UW-1:0]  own_j, own_k;

  function automatic logic [TW-1:0] lat_of(input int u);
    case (u)
      0:       lat_of = TW'(LAT_INT);
      1:       lat_of = TW'(LAT_ADD);
      4:       lat_of = TW'(LAT_DIV);
      default: lat_of = TW'(LAT_MUL);
    endcase
  endfunction

  always_comb begin
    case (in_cls)
      2'd0:    tgt = 3'd0;
      2'd1:    tgt = 3'd1;
      2'd2:    tgt = (ph[2] == P_IDLE) ? 3'd2 : 3'd3;
      default: tgt = 3'd4;
    endcase
  end

  assign in_ready = (ph[tgt] == P_IDLE) && (rrs[in_dst] == NONE);
  assign issue    = in_valid && in_ready;

  always_comb begin
    for (int u = 0; u < NU; u++) begin
      war[u] = 1'b0;
      for (int v = 0; v < NU; v++)
        if (ph[v] == P_READ &&
            ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
          war[u] = 1'b1;
      wreq[u]      = (ph[u] == P_WRITE) && !war[u];
      start_vec[u] = (ph[u] == P_READ) && rj[u] && rk[u];
      fu_busy[u]   = (ph[u] != P_IDLE);
      fu_rdy_j[u]  = rj[u];
      fu_rdy_k[u]  = rk[u];
    end
  end

  always_comb begin
    wb_any = 1'b0;
    wb_u   = NONE;
    wb_reg = '0;
    for (int u = NU - 1; u >= 0; u--)
      if (wreq[u]) begin
        wb_any = 1'b1;
        wb_u   = UW'(u);
        wb_reg = fi[u];
      end
    for (int u = 0; u < NU; u++)
      wb_vec[u] = wb_any && (wb_u == UW'(u));
  end

  assign own_j = (wb_any && rrs[in_src1] == wb_u) ? NONE : rrs[in_src1];
  assign own_k = (wb_any && rrs[in_src2] == wb_u) ? NONE : rrs[in_src2];

  always_comb
    for (int r = 0; r < NREG; r++)
      reg_owner[r*UW +: UW] = rrs[r];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) begin
        ph[u]  <= P_IDLE;
        fi[u]  <= '0;
        fj[u]  <= '0;
        fk[u]  <= '0;
        qj[u]  <= NONE;
        qk[u]  <= NONE;
        rj[u]  <= 1'b0;
        rk[u]  <= 1'b0;
        tmr[u] <= '0;
      end
      for (int r = 0; r < NREG; r++) rrs[r] <= NONE;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (wb_vec[u]) begin
          ph[u] <= P_IDLE;
        end else if (start_vec[u]) begin
          ph[u]  <= P_EXEC;
          tmr[u] <= lat_of(u);
          rj[u]  <= 1'b0;
          rk[u]  <= 1'b0;
        end else if (ph[u] == P_EXEC) begin
          tmr[u] <= tmr[u] - 1'b1;
          if (tmr[u] == TW'(1)) ph[u] <= P_WRITE;
        end
        if (wb_any && qj[u] == wb_u) begin
          rj[u] <= 1'b1;
          qj[u] <= NONE;
        end
        if (wb_any && qk[u] == wb_u) begin
          rk[u] <= 1'b1;
          qk[u] <= NONE;
        end
        if (issue && tgt == UW'(u)) begin
          ph[u] <= P_READ;
          fi[u] <= in_dst;
          fj[u] <= in_src1;
          fk[u] <= in_src2;
          qj[u] <= own_j;
          qk[u] <= own_k;
          rj[u] <= (own_j == NONE);
          rk[u] <= (own_k == NONE);
        end
      end
      if (wb_any) rrs[wb_reg] <= NONE;
      if (issue)  rrs[in_dst] <= tgt;
    end
  end
endmodule

// File: rtl/scoreboard_sched_chk.sv
module scoreboard_sched_chk #(
  parameter int NREG    = 16,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [$clog2(NREG)-1:0] in_dst,
  input logic [4:0]              start_vec,
  input logic [4:0]              wb_vec,
  input logic [$clog2(NREG)-1:0] wb_reg,
  input logic [4:0]              fu_busy,
  input logic [4:0]              fu_rdy_j,
  input logic [4:0]              fu_rdy_k,
  input logic [NREG*3-1:0]       reg_owner
);
  localparam int RW   = $clog2(NREG);
  localparam int LM1  = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int LM2  = (LAT_ADD > LAT_INT) ? LAT_ADD : LAT_INT;
  localparam int LMAX = (LM1 > LM2) ? LM1 : LM2;
  localparam int CW   = $clog2(LMAX + 2);

  logic          prev_iss, prev_wb;
  logic [RW-1:0] prev_dst, prev_wr;
  logic [4:0]    prev_wv;
  logic [2:0]    own_pd, own_pw, own_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_iss <= 1'b0;
      prev_wb  <= 1'b0;
      prev_dst <= '0;
      prev_wr  <= '0;
      prev_wv  <= '0;
    end else begin
      prev_iss <= in_valid && in_ready;
      prev_wb  <= |wb_vec;
      prev_dst <= in_dst;
      prev_wr  <= wb_reg;
      prev_wv  <= wb_vec;
    end
  end

  assign own_pd  = reg_owner[int'(prev_dst)*3 +: 3];
  assign own_pw  = reg_owner[int'(prev_wr)*3 +: 3];
  assign own_cur = reg_owner[int'(in_dst)*3 +: 3];

  AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_vec)); // R9
  AST_ISSUE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    prev_iss |-> own_pd != 3'd7); // R4
  AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    prev_wb |-> (own_pw == 3'd7) && ((fu_busy & prev_wv) == 5'd0)); // R10
  AST_WAW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && own_cur != 3'd7) |-> !in_ready); // R3

  for (genvar g = 0; g < 5; g++) begin : g_unit
    localparam int L = (g == 0) ? LAT_INT : (g == 1) ? LAT_ADD :
                       (g == 4) ? LAT_DIV : LAT_MUL;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt <= '0;
      else if (start_vec[g])                     cnt <= CW'(1);
      else if (cnt != '0 && cnt != CW'(L + 1))   cnt <= cnt + 1'b1;
    end
    AST_EXEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vec[g] |-> cnt == CW'(L + 1)); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_vec[g] |=> !fu_rdy_j[g] && !fu_rdy_k[g]); // R7
  end
endmodule

bind scoreboard_sched scoreboard_sched_chk #(
  .NREG(NREG), .LAT_INT(LAT_INT), .LAT_ADD(LAT_ADD),
  .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_dst(in_dst), .start_vec(start_vec), .wb_vec(wb_vec), .wb_reg(wb_reg),
  .fu_busy(fu_busy), .fu_rdy_j(fu_rdy_j), .fu_rdy_k(fu_rdy_k),
  .reg_owner(reg_owner)
);

// File: tb/tb_scoreboard_sched.sv
`timescale 1ns/1ps
module tb_scoreboard_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_cls = '0;
  logic [3:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [4:0]  start_vec, wb_vec, fu_busy, fu_rdy_j, fu_rdy_k;
  logic [3:0]  wb_reg;
  logic [47:0] reg_owner;

  scoreboard_sched dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .start_vec(start_vec), .wb_vec(wb_vec), .wb_reg(wb_reg),
    .fu_busy(fu_busy), .fu_rdy_j(fu_rdy_j), .fu_rdy_k(fu_rdy_k),
    .reg_owner(reg_owner)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int st_c [5];
  int wb_c [5];
  int wb_r [5];

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk)
    for (int u = 0; u < 5; u++) begin
      if (start_vec[u]) st_c[u] = cyc;
      if (wb_vec[u]) begin wb_c[u] = cyc; wb_r[u] = int'(wb_reg); end
    end

  function automatic int own(input int r);
    return int'(reg_owner[r*3 +: 3]);
  endfunction

  function automatic int unit_of(input int c);
    return (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 2 : 4;
  endfunction

  function automatic int lat_of(input int c);
    return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 10 : 40;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int u = 0; u < 5; u++) begin st_c[u] = -1; wb_c[u] = -1; wb_r[u] = -1; end
  endtask

  task automatic issue(input int c, input int d, input int s1, input int s2,
                       output int ic);
    int guard = 0;
    in_cls = 2'(c); in_dst = 4'(d); in_src1 = 4'(s1); in_src2 = 4'(s2);
    in_valid = 1'b1;
    #0.5;
    while (!in_ready && guard < 300) begin
      @(negedge clk); #0.5; guard++;
    end
    ic = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (fu_busy != 5'd0 && guard < 300) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    int c0, c1, c2, ca, cd, ci, cp, cc, pu, p, q, m;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(fu_busy), 0);
    chk("R1 start", int'(start_vec), 0);
    chk("R1 wb", int'(wb_vec), 0);
    #0.5;
    chk("R1 ready", int'(in_ready), 1);
    for (int r = 0; r < 16; r++) chk("R1 owner", own(r), 7);
    @(negedge clk);

    // R4 R5 R6 R10 sweep over every class and destination
    for (int c = 0; c < 4; c++)
      for (int d = 0; d < 16; d++) begin
        int ic, u;
        u = unit_of(c);
        clr();
        issue(c, d, (d + 1) % 16, (d + 2) % 16, ic);
        chk("R4 owner code", own(d), u);
        wait_idle();
        chk("R5 start cycle", st_c[u], ic + 1);
        chk("R6 write cycle", wb_c[u], ic + lat_of(c) + 2);
        chk("R6 write reg", wb_r[u], d);
        chk("R10 owner cleared", own(d), 7);
      end

    // R2 structural: two multipliers then a stall
    clr();
    issue(2, 1, 8, 9, c0);
    issue(2, 2, 8, 9, c1);
    chk("R2 second mul accepted", c1, c0 + 1);
    chk("R2 second mul unit", own(2), 3);
    issue(2, 3, 8, 9, c2);
    chk("R2 third mul waits", c2, c0 + 13);
    chk("R2 third mul unit", own(3), 2);
    wait_idle();

    // R3 WAW: add to divider's destination waits for its write
    clr();
    issue(3, 5, 8, 9, cd);
    issue(1, 5, 8, 9, ca);
    chk("R3 waw release", ca, cd + 43);
    wait_idle();

    // R5 R7 RAW on each source side from several producers
    for (int k = 0; k < 3; k++)
      for (int side = 0; side < 2; side++) begin
        int pc, guard;
        pc = (k == 0) ? 0 : (k == 1) ? 2 : 3;
        pu = unit_of(pc);
        clr();
        issue(pc, 6, 12, 13, cp);
        if (side == 0) issue(1, 7, 6, 0, cc);
        else           issue(1, 7, 0, 6, cc);
        chk("R5 consumer accepted", cc, cp + 1);
        chk("R5 waiting flag", side == 0 ? int'(fu_rdy_j[1]) : int'(fu_rdy_k[1]), 0);
        guard = 0;
        while (!wb_vec[pu] && guard < 100) begin @(negedge clk); guard++; end
        @(negedge clk);
        chk("R7 flags set by write", int'(fu_rdy_j[1] & fu_rdy_k[1]), 1);
        chk("R5 start after write", int'(start_vec[1]), 1);
        @(negedge clk);
        chk("R7 flags cleared by read", int'(fu_rdy_j[1] | fu_rdy_k[1]), 0);
        wait_idle();
        chk("R5 start cycle", st_c[1], wb_c[pu] + 1);
        chk("R6 consumer write", wb_c[1], st_c[1] + 3);
      end

    // R8 WAR: integer result held until adder reads its ready source
    clr();
    issue(3, 1, 8, 9, cd);
    issue(1, 2, 1, 3, ca);
    issue(0, 3, 4, 5, ci);
    wait_until(cd + 10);
    chk("R8 held busy", int'(fu_busy[0]), 1);
    chk("R8 no write", int'(wb_vec[0]), 0);
    chk("R8 owner kept", own(3), 0);
    wait_idle();
    chk("R8 divider write", wb_c[4], cd + 42);
    chk("R8 adder start", st_c[1], wb_c[4] + 1);
    chk("R8 integer write", wb_c[0], wb_c[4] + 2);
    chk("R8 adder write", wb_c[1], wb_c[4] + 4);

    // R9 priority: integer over adder, multiplier over divider
    clr();
    issue(1, 8, 10, 11, p);
    issue(0, 9, 10, 11, q);
    wait_idle();
    chk("R9 integer first", wb_c[0], p + 4);
    chk("R9 adder next", wb_c[1], p + 5);
    clr();
    issue(3, 12, 0, 1, cd);
    wait_until(cd + 30);
    issue(2, 13, 0, 1, m);
    chk("R9 mul accept", m, cd + 30);
    wait_idle();
    chk("R9 multiplier first", wb_c[2], cd + 42);
    chk("R9 divider next", wb_c[4], cd + 43);

    // R10 accept in the write cycle of a source
    clr();
    issue(0, 10, 0, 1, p);
    wait_until(p + 3);
    issue(1, 11, 10, 2, q);
    chk("R10 accepted in write cycle", q, p + 3);
    wait_idle();
    chk("R10 producer write", wb_c[0], p + 3);
    chk("R10 consumer start", st_c[1], p + 4);
    chk("R10 all idle", int'(fu_busy), 0);

    summary();
    $finish;
  end
endmodule